// File: doc/BRIEF.md
# Three-Band Cascaded Biquad Equalizer

This block filters a stereo audio stream through three second-order IIR sections in series: a low-band section, then a mid-band section, then a high-band section. Each section's output is the input of the next. Every section evaluates five coefficient products per sample. The products for one channel sample are not computed on dedicated hardware. Instead, a parameterized pool of `LANES` multipliers handles them over successive fabric cycles, and a wide accumulator collects the results. The left sample is processed first and the right sample second, on the same scheduled datapath. The outputs update together, and a one-cycle completion strobe marks the update.

An outside agent loads the fifteen coefficients through a simple write port into a staging bank. When a new sample is accepted, the staging bank is copied into the working bank. Every sample is therefore computed with a single, consistent coefficient set. Each section keeps two past inputs and two past outputs per channel. With the default two lanes, a stereo sample needs 18 fabric cycles. This is far inside the roughly thousand-cycle budget of a 48 kHz stream on a 50 MHz clock.

Top module: `eq3_cascade`

## Requirements
- R1: After reset, `out_left`, `out_right` and `out_done` are zero. All per-section history is zero. Every section's coefficients form a unity passthrough (feed-forward tap 0 = 16384, all others 0), so the output equals the input.
- R2: Coefficient index `cfg_idx = 5*section + tap` (section 0 low, 1 mid, 2 high). The taps in order are b0, b1, b2, a1, a2, each signed Q2.14. A section computes acc = b0·x + b1·x[n-1] + b2·x[n-2] − a1·y[n-1] − a2·y[n-2], and its output is floor(acc / 2^14).
- R3: Section 0's output feeds section 1, and section 1's output feeds section 2. `out_left`/`out_right` are the section 2 outputs.
- R4: Each section output is clamped to [−32768, 32767]. The accumulator is wide enough that five full-scale products never wrap before the clamp.
- R5: The left and right channels keep separate history in every section. A signal on one channel never changes the other channel's output.
- R6: `out_done` is a single-cycle pulse. `out_left`/`out_right` change only in a cycle in which `out_done` is high.
- R7: `out_done` rises exactly 2·3·ceil(5/LANES) clock edges after the edge that accepts `in_valid` (18 for the defaults).
- R8: `in_valid` pulses that arrive while a sample is in progress are ignored. They produce no completion and leave outputs and history untouched.
- R9: Coefficient writes land in a staging bank. The staging bank is copied into the working bank on the edge that accepts a sample. A write made while a sample is being processed affects only later samples. Writes to an index of 15 or above are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | New stereo sample strobe |
| in_left | input | 16 | Left input sample, signed |
| in_right | input | 16 | Right input sample, signed |
| cfg_we | input | 1 | Coefficient staging write enable |
| cfg_idx | input | 4 | Coefficient index, 5*section + tap |
| cfg_data | input | 16 | Coefficient value, signed Q2.14 |
| out_left | output | 16 | Filtered left sample |
| out_right | output | 16 | Filtered right sample |
| out_done | output | 1 | One-cycle pulse when both outputs update |

## Verification
The bench targets the cases where a time-shared datapath most easily goes wrong:
- **Coefficient rewrite during processing.** A rewrite issued mid-sample must not touch the current sample. A design that reads the staging bank directly would produce a half-old, half-new result for that sample.
- **Extra `in_valid` pulse.** A pulse arriving during processing must be dropped. A sequencer that restarts on it would emit a second completion or corrupt the history.
- **Full-scale inputs with gains above one.** These drive intermediate sums beyond 32 bits and outputs past full scale. A narrow accumulator or a missing clamp would flip the sign instead of saturating.
- **Single-channel impulses and negative odd accumulations.** These expose shared left/right history and rounding toward zero instead of floor.

// File: rtl/eq3_pkg.sv
package eq3_pkg;
  localparam int TAPS = 5;

  typedef enum logic [2:0] {
    TAP_B0 = 3'd0,
    TAP_B1 = 3'd1,
    TAP_B2 = 3'd2,
    TAP_A1 = 3'd3,
    TAP_A2 = 3'd4
  } tap_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction
endpackage

// File: rtl/eq3_coef_bank.sv
module eq3_coef_bank #(
  parameter int NCOEF = 15,
  parameter int CW    = 16,
  parameter int IDXW  = 4,
  parameter int FRAC  = 14
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [IDXW-1:0]            idx,
  input  logic [CW-1:0]              wdata,
  input  logic                       load,
  output logic [NCOEF-1:0][CW-1:0]   act
);
  logic [NCOEF-1:0][CW-1:0] stage_q;

  for (genvar i = 0; i < NCOEF; i++) begin : g_entry
    localparam logic [CW-1:0] INIT = ((i % eq3_pkg::TAPS) == 0) ? CW'(1 << FRAC) : '0;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[i] <= INIT;
        act[i]     <= INIT;
      end else begin
        if (we && (idx == IDXW'(i))) stage_q[i] <= wdata;
        if (load) act[i] <= stage_q[i];
      end
    end
  end
endmodule

// File: rtl/eq3_seq.sv
module eq3_seq #(
  parameter int SECS  = 3,
  parameter int STEPS = 3,
  localparam int STW  = $clog2(STEPS + 1),
  localparam int SCW  = $clog2(SECS + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  output logic           busy,
  output logic           ch,
  output logic [SCW-1:0] sec,
  output logic [STW-1:0] step,
  output logic           sec_end
);
  assign sec_end = busy && (step == STW'(STEPS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      ch   <= 1'b0;
      sec  <= '0;
      step <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        ch   <= 1'b0;
        sec  <= '0;
        step <= '0;
      end
    end else if (sec_end) begin
      step <= '0;
      if (sec == SCW'(SECS - 1)) begin
        sec <= '0;
        if (ch) begin
          ch   <= 1'b0;
          busy <= 1'b0;
        end else begin
          ch <= 1'b1;
        end
      end else begin
        sec <= sec + 1'b1;
      end
    end else begin
      step <= step + 1'b1;
    end
  end
endmodule

// File: rtl/eq3_mac.sv
module eq3_mac #(
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int FRAC  = 14,
  parameter int ACC_W = 36,
  parameter int LANES = 2,
  parameter int STEPS = 3,
  localparam int TAPS = eq3_pkg::TAPS,
  localparam int STW  = $clog2(STEPS + 1),
  localparam int PW   = CW + DW
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     busy,
  input  logic [STW-1:0]           step,
  input  logic [TAPS-1:0][CW-1:0]  coef,
  input  logic [TAPS-1:0][DW-1:0]  opnd,
  output logic signed [DW-1:0]     y_out
);
  localparam logic signed [ACC_W-1:0] HI = {{(ACC_W-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] LO = {{(ACC_W-DW+1){1'b1}}, {(DW-1){1'b0}}};

  function automatic logic signed [DW-1:0] requant(input logic signed [ACC_W-1:0] a);
    logic signed [ACC_W-1:0] s;
    s = a >>> FRAC;
    if (s > HI) s = HI;
    else if (s < LO) s = LO;
    return s[DW-1:0];
  endfunction

  logic signed [ACC_W-1:0] lane_p [LANES];
  logic signed [ACC_W-1:0] acc_q, acc_nx;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic signed [CW-1:0] c;
    logic signed [DW-1:0] o;
    logic signed [PW-1:0] p;
    logic                 neg, hit;
    int                   tap;
    always_comb begin
      tap = int'(step) * LANES + l;
      c   = '0;
      o   = '0;
      neg = 1'b0;
      hit = 1'b0;
      for (int t = 0; t < TAPS; t++) begin
        if (tap == t) begin
          c   = coef[t];
          o   = opnd[t];
          neg = (t >= int'(eq3_pkg::TAP_A1));
          hit = 1'b1;
        end
      end
      p = c * o;
      if (!hit) lane_p[l] = '0;
      else if (neg) lane_p[l] = -{{(ACC_W-PW){p[PW-1]}}, p};
      else lane_p[l] = {{(ACC_W-PW){p[PW-1]}}, p};
    end
  end

  always_comb begin
    acc_nx = (step == '0) ? '0 : acc_q;
    for (int l = 0; l < LANES; l++) acc_nx = acc_nx + lane_p[l];
  end

  assign y_out = requant(acc_nx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else if (busy) acc_q <= acc_nx;
  end
endmodule

// File: rtl/eq3_cascade.sv
module eq3_cascade #(
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int FRAC  = 14,
  parameter int ACC_W = 36,
  parameter int LANES = 2,
  parameter int SECS  = 3,
  localparam int TAPS  = eq3_pkg::TAPS,
  localparam int NCOEF = SECS * TAPS,
  localparam int IDXW  = $clog2(NCOEF),
  localparam int STEPS = eq3_pkg::ceil_div(TAPS, LANES),
  localparam int STW   = $clog2(STEPS + 1),
  localparam int SCW   = $clog2(SECS + 1),
  localparam int LAT   = 2 * SECS * STEPS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [DW-1:0]   in_left,
  input  logic [DW-1:0]   in_right,
  input  logic            cfg_we,
  input  logic [IDXW-1:0] cfg_idx,
  input  logic [CW-1:0]   cfg_data,
  output logic [DW-1:0]   out_left,
  output logic [DW-1:0]   out_right,
  output logic            out_done
);
  logic                      busy_w, ch_w, sec_end_w, accept_w;
  logic [SCW-1:0]            sec_w;
  logic [STW-1:0]            step_w;
  logic [NCOEF-1:0][CW-1:0]  coef_act;
  logic [TAPS-1:0][CW-1:0]   coef_sec;
  logic [TAPS-1:0][DW-1:0]   opnd;
  logic signed [DW-1:0]      y_new;

  logic [DW-1:0] x1_q [2][SECS];
  logic [DW-1:0] x2_q [2][SECS];
  logic [DW-1:0] y1_q [2][SECS];
  logic [DW-1:0] y2_q [2][SECS];
  logic [DW-1:0] cur_q, rin_q, lres_q;

  assign accept_w = in_valid && !busy_w;

  eq3_coef_bank #(.NCOEF(NCOEF), .CW(CW), .IDXW(IDXW), .FRAC(FRAC)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx), .wdata(cfg_data),
    .load(accept_w), .act(coef_act));

  eq3_seq #(.SECS(SECS), .STEPS(STEPS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(in_valid), .busy(busy_w), .ch(ch_w),
    .sec(sec_w), .step(step_w), .sec_end(sec_end_w));

  always_comb begin
    coef_sec = '0;
    for (int s = 0; s < SECS; s++)
      if (sec_w == SCW'(s))
        for (int t = 0; t < TAPS; t++) coef_sec[t] = coef_act[s*TAPS+t];
    opnd[0] = cur_q;
    opnd[1] = x1_q[ch_w][sec_w];
    opnd[2] = x2_q[ch_w][sec_w];
    opnd[3] = y1_q[ch_w][sec_w];
    opnd[4] = y2_q[ch_w][sec_w];
  end

  eq3_mac #(.DW(DW), .CW(CW), .FRAC(FRAC), .ACC_W(ACC_W), .LANES(LANES), .STEPS(STEPS)) u_mac (
    .clk(clk), .rst_n(rst_n), .busy(busy_w), .step(step_w), .coef(coef_sec),
    .opnd(opnd), .y_out(y_new));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++)
        for (int s = 0; s < SECS; s++) begin
          x1_q[c][s] <= '0;
          x2_q[c][s] <= '0;
          y1_q[c][s] <= '0;
          y2_q[c][s] <= '0;
        end
      cur_q     <= '0;
      rin_q     <= '0;
      lres_q    <= '0;
      out_left  <= '0;
      out_right <= '0;
      out_done  <= 1'b0;
    end else begin
      out_done <= 1'b0;
      if (accept_w) begin
        cur_q <= in_left;
        rin_q <= in_right;
      end
      if (sec_end_w) begin
        x2_q[ch_w][sec_w] <= x1_q[ch_w][sec_w];
        x1_q[ch_w][sec_w] <= cur_q;
        y2_q[ch_w][sec_w] <= y1_q[ch_w][sec_w];
        y1_q[ch_w][sec_w] <= y_new;
        if (sec_w == SCW'(SECS - 1)) begin
          if (!ch_w) begin
            lres_q <= y_new;
            cur_q  <= rin_q;
          end else begin
            out_left  <= lres_q;
            out_right <= y_new;
            out_done  <= 1'b1;
          end
        end else begin
          cur_q <= y_new;
        end
      end
    end
  end
endmodule

// File: rtl/eq3_cascade_chk.sv
module eq3_cascade_chk #(
  parameter int DW   = 16,
  parameter int SECS = 3,
  parameter int LAT  = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          accept,
  input logic          busy,
  input logic          sec_end,
  input logic          done,
  input logic [DW-1:0] left,
  input logic [DW-1:0] right
);
  logic [7:0] cyc_q;
  logic [7:0] secs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q  <= '0;
      secs_q <= '0;
    end else if (accept) begin
      cyc_q  <= '0;
      secs_q <= '0;
    end else begin
      if (cyc_q != 8'hFF) cyc_q <= cyc_q + 1'b1;
      if (sec_end && secs_q != 8'hFF) secs_q <= secs_q + 1'b1;
    end
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(left) || !$stable(right)) |-> done);

  // R7
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cyc_q == 8'(LAT)));

  // R3
  section_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (secs_q == 8'(2 * SECS)));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind eq3_cascade eq3_cascade_chk #(.DW(DW), .SECS(SECS), .LAT(LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept_w), .busy(busy_w), .sec_end(sec_end_w),
  .done(out_done), .left(out_left), .right(out_right));

// File: tb/eq3_cascade_test.sv
`timescale 1ns/1ps
module eq3_cascade_test;
  localparam int LAT = 18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_left = '0, in_right = '0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [15:0] cfg_data = '0;
  logic [15:0] out_left, out_right;
  logic        out_done;

  always #2 clk = ~clk;

  eq3_cascade uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .out_left(out_left), .out_right(out_right), .out_done(out_done));

  typedef struct {
    int    l;
    int    r;
    string req;
  } exp_t;

  exp_t   sb[$];
  int     n_chk = 0, n_bad = 0;
  bit     ended = 1'b0;
  longint stage_c [15];
  longint act_c [15];
  longint hx1 [2][3], hx2 [2][3], hy1 [2][3], hy2 [2][3];

  task automatic check(input string req, input string what, input longint got, input longint exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic longint clamp16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  // Reference: one channel sample through the three sections, in plain integer arithmetic
  function automatic longint run_chan(input int c, input longint x);
    longint v, acc, y, q;
    v = x;
    for (int s = 0; s < 3; s++) begin
      acc = act_c[s*5] * v + act_c[s*5+1] * hx1[c][s] + act_c[s*5+2] * hx2[c][s]
          - act_c[s*5+3] * hy1[c][s] - act_c[s*5+4] * hy2[c][s];
      q = acc / 16384;
      if (acc < 0 && q * 16384 != acc) q = q - 1;
      y = clamp16(q);
      hx2[c][s] = hx1[c][s]; hx1[c][s] = v;
      hy2[c][s] = hy1[c][s]; hy1[c][s] = y;
      v = y;
    end
    return v;
  endfunction

  task automatic write_coef(input int idx, input longint val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_data = 16'(val);
    @(negedge clk);
    cfg_we = 1'b0;
    if (idx < 15) stage_c[idx] = val;
  endtask

  // mode 0: plain; 1: coefficient rewrite mid-sample; 2: extra valid mid-sample
  task automatic send(input int l, input int r, input string req, input int mode);
    exp_t e;
    int   cnt;
    @(negedge clk);
    in_valid = 1'b1; in_left = 16'(l); in_right = 16'(r);
    for (int i = 0; i < 15; i++) act_c[i] = stage_c[i];
    e.l = int'(run_chan(0, l));
    e.r = int'(run_chan(1, r));
    e.req = req;
    sb.push_back(e);
    @(negedge clk);
    in_valid = 1'b0;
    cnt = 1;
    if (mode == 1) begin
      cfg_we = 1'b1; cfg_idx = 4'd0; cfg_data = 16'(8192);
      @(negedge clk); cnt++;
      cfg_we = 1'b0; stage_c[0] = 8192;
    end
    if (mode == 2) begin
      repeat (4) begin @(negedge clk); cnt++; end
      in_valid = 1'b1; in_left = 16'(12345); in_right = 16'(-23456);
      @(negedge clk); cnt++;
      in_valid = 1'b0;
    end
    while (!out_done && cnt < 60) begin @(negedge clk); cnt++; end
    check("R7", "latency", cnt - 1, LAT);
    repeat (3) @(negedge clk);
  endtask

  // monitor: compare each completion against the scoreboard
  always @(negedge clk) begin
    if (rst_n && out_done) begin
      if (sb.size() == 0) begin
        check("R8", "unexpected completion", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(e.req, "left", longint'($signed(out_left)), e.l);
        check(e.req, "right", longint'($signed(out_right)), e.r);
      end
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check("watchdog", "timeout", 1, 0);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 15; i++) stage_c[i] = (i % 5 == 0) ? 16384 : 0;
    for (int c = 0; c < 2; c++)
      for (int s = 0; s < 3; s++) begin
        hx1[c][s] = 0; hx2[c][s] = 0; hy1[c][s] = 0; hy2[c][s] = 0;
      end
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "out_done", out_done, 0);
    check("R1", "out_left", out_left, 0);
    check("R1", "out_right", out_right, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 passthrough after reset
    send(1000, -2000, "R1", 0);
    send(32767, -32768, "R1", 0);

    // R2 R3 distinct sections in cascade
    write_coef(0, 4096);  write_coef(1, 8192);  write_coef(2, 4096);
    write_coef(3, -13000); write_coef(4, 4000);
    write_coef(5, 20000); write_coef(6, -10000); write_coef(7, 3000);
    write_coef(8, 5000);  write_coef(9, -2000);
    write_coef(10, 12000); write_coef(11, 0); write_coef(12, -3000);
    write_coef(13, 0);    write_coef(14, 1000);
    send(10000, 10000, "R2", 0);
    send(10000, -10000, "R3", 0);
    send(-7777, 3333, "R2", 0);
    send(0, 0, "R3", 0);
    send(-1, 1, "R2", 0);
    // R5 single-channel impulse
    send(0, 20000, "R5", 0);
    send(0, 0, "R5", 0);
    send(0, 0, "R5", 0);

    // R4 gains above one driven to full scale
    for (int i = 0; i < 15; i++) write_coef(i, (i % 5 == 0) ? 24576 : 0);
    send(32767, -32768, "R4", 0);
    send(30000, -30000, "R4", 0);
    // R4 wide accumulator: three products of 2^30 each
    write_coef(0, -32768); write_coef(1, -32768); write_coef(2, -32768);
    write_coef(5, 16384); write_coef(10, 16384);
    send(-32768, 100, "R4", 0);
    send(-32768, 100, "R4", 0);
    send(-32768, 100, "R4", 0);

    // R9 mid-sample rewrite applies only from the next sample
    for (int i = 0; i < 15; i++) write_coef(i, (i % 5 == 0) ? 16384 : 0);
    send(5000, -5000, "R9", 1);
    send(5001, -4999, "R9", 0);
    // R9 out-of-range index ignored
    write_coef(15, 1234);
    send(3000, 3000, "R9", 0);

    // R8 extra valid during processing
    send(4000, -4000, "R8", 2);
    send(4001, -4001, "R8", 0);
    repeat (10) @(negedge clk);
    check("R8", "scoreboard drained", sb.size(), 0);
    finish_run();
  end
endmodule